// File: doc/BRIEF.md
# Trap Condition Comparator

This combinational unit decides whether a conditional trap instruction fires. Two register operands are related to each other in five ways at once: signed less, signed greater, equal, unsigned less and unsigned greater. A five-bit condition mask picks which of these relations fire the trap. If any selected relation holds, the take-trap output is asserted.

A separate vector of forced cause bits overrides the comparison. When any of its bits is set, the trap is taken whatever the operands and the mask are. A word-mode input limits the comparison to the low half of each operand. That low half is sign-extended for the signed relations and zero-extended for the unsigned ones. The five relation flags are also brought out as a debug vector.

Top module: `trapcmp_unit`

## Requirements
- R1: The relation vector `rel_flags_o` has unsigned-greater in bit 0, unsigned-less in bit 1, equal in bit 2, signed-greater in bit 3 and signed-less in bit 4.
- R2: With `word_mode_i` low, the signed relations compare the full 64-bit operands as two's-complement numbers.
- R3: With `word_mode_i` low, the unsigned relations and equality compare the full 64-bit operands as unsigned numbers.
- R4: With `word_mode_i` high, the signed relations compare bits 31:0 of each operand after sign extension.
- R5: With `word_mode_i` high, the unsigned relations compare bits 31:0 of each operand after zero extension.
- R6: With `word_mode_i` high, bits 63:32 of the operands have no effect on any output. Operands that differ only there compare equal.
- R7: `take_trap_o` is high when the bitwise AND of `rel_flags_o` and `cond_mask_i` is non-zero.
- R8: A non-zero `force_cause_i` drives `take_trap_o` high for any operands and any mask.
- R9: When `cond_mask_i` and `force_cause_i` are both zero, `take_trap_o` is low for any operands.
- R10: Exactly one of signed-less, equal and signed-greater is set. Exactly one of unsigned-less, equal and unsigned-greater is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second operand |
| cond_mask_i | input | 5 | Selects which relations fire the trap (bit layout as in R1) |
| word_mode_i | input | 1 | High: compare only bits 31:0 |
| force_cause_i | input | 5 | Forced trap causes; any set bit fires the trap |
| take_trap_o | output | 1 | Trap decision |
| rel_flags_o | output | 5 | Debug copy of the five relation results |

## Verification
A forced cause and a comparison hit can both be present on the same input vector. The bench drives vectors where both are present, vectors where only one is, and vectors with a mask that misses the relations while a cause bit is set. The bench predicts the take-trap value in each case from its own 64-bit signed and unsigned integer model. Randomized vectors also mix cause bits, masks and both operand widths. About a quarter of them use equal operands, so that equality overlaps the other relations.

// File: rtl/trapcmp_pkg.sv
package trapcmp_pkg;
  localparam int REL_W   = 5;
  localparam int REL_UGT = 0;
  localparam int REL_ULT = 1;
  localparam int REL_EQ  = 2;
  localparam int REL_SGT = 3;
  localparam int REL_SLT = 4;
  typedef logic [REL_W-1:0] rel_vec_t;
endpackage

// File: rtl/trapcmp_operand_prep.sv
module trapcmp_operand_prep #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              word_mode_i,
  output logic [DATA_W-1:0] sa_o,
  output logic [DATA_W-1:0] sb_o,
  output logic [DATA_W-1:0] ua_o,
  output logic [DATA_W-1:0] ub_o
);
  localparam int HALF_W = DATA_W / 2;

  // Narrow to the low half, extending with its top bit or with zeros.
  function automatic logic [DATA_W-1:0] narrow(input logic [DATA_W-1:0] x,
                                               input logic use_sign);
    logic fill;
    fill = use_sign & x[HALF_W-1];
    return {{(DATA_W-HALF_W){fill}}, x[HALF_W-1:0]};
  endfunction

  always_comb begin
    if (word_mode_i) begin
      sa_o = narrow(opa_i, 1'b1);
      sb_o = narrow(opb_i, 1'b1);
      ua_o = narrow(opa_i, 1'b0);
      ub_o = narrow(opb_i, 1'b0);
    end else begin
      sa_o = opa_i;
      sb_o = opb_i;
      ua_o = opa_i;
      ub_o = opb_i;
    end
  end
endmodule

// File: rtl/trapcmp_relations.sv
module trapcmp_relations
  import trapcmp_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] sa_i,
  input  logic [DATA_W-1:0] sb_i,
  input  logic [DATA_W-1:0] ua_i,
  input  logic [DATA_W-1:0] ub_i,
  output rel_vec_t          rel_o
);
  localparam int KINDS = 2;   // 0: unsigned, 1: signed

  // Signed order equals unsigned order once the top bits are flipped.
  function automatic logic biased_less(input logic [DATA_W-1:0] x,
                                       input logic [DATA_W-1:0] y,
                                       input logic flip);
    logic [DATA_W-1:0] xb, yb;
    xb = {x[DATA_W-1] ^ flip, x[DATA_W-2:0]};
    yb = {y[DATA_W-1] ^ flip, y[DATA_W-2:0]};
    return xb < yb;
  endfunction

  logic [DATA_W-1:0] lhs [KINDS];
  logic [DATA_W-1:0] rhs [KINDS];
  logic [KINDS-1:0]  lt_v;
  logic [KINDS-1:0]  gt_v;
  logic              eq_w;

  always_comb begin
    lhs[0] = ua_i;
    rhs[0] = ub_i;
    lhs[1] = sa_i;
    rhs[1] = sb_i;
  end

  for (genvar k = 0; k < KINDS; k++) begin : g_kind
    assign lt_v[k] = biased_less(lhs[k], rhs[k], (k == 1));
    assign gt_v[k] = biased_less(rhs[k], lhs[k], (k == 1));
  end

  assign eq_w = (ua_i == ub_i);

  always_comb begin
    rel_o          = '0;
    rel_o[REL_UGT] = gt_v[0];
    rel_o[REL_ULT] = lt_v[0];
    rel_o[REL_EQ]  = eq_w;
    rel_o[REL_SGT] = gt_v[1];
    rel_o[REL_SLT] = lt_v[1];
  end
endmodule

// File: rtl/trapcmp_decide.sv
module trapcmp_decide
  import trapcmp_pkg::*;
#(
  parameter int FORCE_W = 5
) (
  input  rel_vec_t           rel_i,
  input  rel_vec_t           mask_i,
  input  logic [FORCE_W-1:0] force_i,
  output logic               hit_any_o,
  output logic               force_any_o,
  output logic               take_o
);
  rel_vec_t hits;
  assign hits        = rel_i & mask_i;
  assign hit_any_o   = |hits;
  assign force_any_o = |force_i;
  assign take_o      = hit_any_o | force_any_o;
endmodule

// File: rtl/trapcmp_unit.sv
module trapcmp_unit
  import trapcmp_pkg::*;
#(
  parameter int DATA_W  = 64,
  parameter int FORCE_W = 5
) (
  input  logic [DATA_W-1:0]  opa_i,
  input  logic [DATA_W-1:0]  opb_i,
  input  logic [REL_W-1:0]   cond_mask_i,
  input  logic               word_mode_i,
  input  logic [FORCE_W-1:0] force_cause_i,
  output logic               take_trap_o,
  output logic [REL_W-1:0]   rel_flags_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] sa_w, sb_w, ua_w, ub_w;
  rel_vec_t          rel_w;
  logic              hit_any_w, force_any_w, take_w;

  trapcmp_operand_prep #(.DATA_W(DATA_W)) u_prep (
    .opa_i(opa_i), .opb_i(opb_i), .word_mode_i(word_mode_i),
    .sa_o(sa_w), .sb_o(sb_w), .ua_o(ua_w), .ub_o(ub_w)
  );

  trapcmp_relations #(.DATA_W(DATA_W)) u_rel (
    .sa_i(sa_w), .sb_i(sb_w), .ua_i(ua_w), .ub_i(ub_w), .rel_o(rel_w)
  );

  trapcmp_decide #(.FORCE_W(FORCE_W)) u_dec (
    .rel_i(rel_w), .mask_i(cond_mask_i), .force_i(force_cause_i),
    .hit_any_o(hit_any_w), .force_any_o(force_any_w), .take_o(take_w)
  );

  assign take_trap_o = take_w;
  assign rel_flags_o = rel_w;

  always_comb begin
    AST_FORCE_TAKES: assert (!(force_cause_i != '0) || take_trap_o); // R8
    AST_IDLE_NO_TRAP: assert (!(cond_mask_i == '0 && force_cause_i == '0) || !take_trap_o); // R9
    AST_MASK_HIT_TAKES: assert (!((rel_flags_o & cond_mask_i) != '0) || take_trap_o); // R7
    AST_SIGNED_ONE_HOT: assert ($countones({rel_flags_o[REL_SLT], rel_flags_o[REL_EQ], rel_flags_o[REL_SGT]}) == 1); // R10
    AST_UNSIGNED_ONE_HOT: assert ($countones({rel_flags_o[REL_ULT], rel_flags_o[REL_EQ], rel_flags_o[REL_UGT]}) == 1); // R10
    AST_WORD_LOW_EQUAL: assert (!(word_mode_i && opa_i[HALF_W-1:0] == opb_i[HALF_W-1:0]) || rel_flags_o[REL_EQ]); // R6
  end
endmodule

// File: tb/trapcmp_unit_tb_top.sv
module trapcmp_unit_tb_top;
  localparam int FORCE_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic [63:0]        opa, opb;
  logic [4:0]         mask;
  logic               wm;
  logic [FORCE_W-1:0] force_c;
  logic               take;
  logic [4:0]         flags;

  trapcmp_unit dut_i (
    .opa_i(opa), .opb_i(opb), .cond_mask_i(mask), .word_mode_i(wm),
    .force_cause_i(force_c), .take_trap_o(take), .rel_flags_o(flags)
  );

  typedef struct {
    logic [5:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Independent model: {take, slt, sgt, eq, ult, ugt}
  function automatic logic [5:0] model(input logic [63:0] a, input logic [63:0] b,
                                       input logic [4:0] m, input logic w,
                                       input logic [FORCE_W-1:0] f);
    longint          s_a, s_b;
    longint unsigned u_a, u_b;
    logic [4:0]      r;
    if (w) begin
      s_a = longint'($signed(a[31:0]));
      s_b = longint'($signed(b[31:0]));
      u_a = longint'(a[31:0]);
      u_b = longint'(b[31:0]);
    end else begin
      s_a = $signed(a);
      s_b = $signed(b);
      u_a = a;
      u_b = b;
    end
    r[0] = u_a > u_b;
    r[1] = u_a < u_b;
    r[2] = u_a == u_b;
    r[3] = s_a > s_b;
    r[4] = s_a < s_b;
    return {((r & m) != 0) || (f != 0), r};
  endfunction

  task automatic drive(input logic [63:0] a, input logic [63:0] b, input logic [4:0] m,
                       input logic w, input logic [FORCE_W-1:0] f, input string tag);
    item_t it;
    @(negedge clk);
    opa = a; opb = b; mask = m; wm = w; force_c = f;
    it.exp = model(a, b, m, w, f);
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares one item per cycle, one time unit after the edge
  always begin
    @(posedge clk);
    #1;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if ({take, flags} !== it.exp) begin
        errors++;
        $display("FAIL %s: got take=%b flags=%b expected take=%b flags=%b",
                 it.tag, take, flags, it.exp[5], it.exp[4:0]);
      end
    end
  end

  initial begin
    opa = '0; opb = '0; mask = '0; wm = 1'b0; force_c = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(64'd0, 64'd0, 5'b00000, 1'b0, '0, "R9 R1 reset state, idle inputs");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b10000, 1'b0, '0, "R2 R7 dword signed less hit");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b01000, 1'b0, '0, "R2 R7 dword signed greater miss");
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 5'b00001, 1'b0, '0, "R3 R1 dword unsigned greater hit");
    drive(64'd5, 64'd7, 5'b00010, 1'b0, '0, "R3 dword unsigned less");
    drive(64'hFFFF_FFFF_8000_0000, 64'd1, 5'b10000, 1'b1, '0, "R4 word signed less");
    drive(64'hFFFF_FFFF_8000_0000, 64'd1, 5'b00001, 1'b1, '0, "R5 word unsigned greater");
    drive(64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 5'b01010, 1'b1, '0, "R4 R5 word mixed");
    drive(64'h1234_5678_0000_0042, 64'hABCD_EF00_0000_0042, 5'b00100, 1'b1, '0, "R6 word upper half ignored");
    drive(64'h1234_5678_0000_0042, 64'hABCD_EF00_0000_0042, 5'b00100, 1'b0, '0, "R2 R3 same operands in dword mode");
    drive(64'd3, 64'd9, 5'b00000, 1'b0, 5'b00100, "R8 forced cause, empty mask");
    drive(64'd3, 64'd9, 5'b01001, 1'b0, 5'b10000, "R8 forced cause, mask misses");
    drive(64'd3, 64'd9, 5'b10010, 1'b1, 5'b00001, "R8 R7 forced cause and hit together");
    drive(64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 5'b11111, 1'b0, '0, "R7 R10 full mask extremes");
    drive(64'hDEAD_BEEF_0000_0001, 64'h0000_0000_FFFF_FFFF, 5'b00000, 1'b1, '0, "R9 empty mask no trap");
    for (int i = 0; i < 48; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = (i % 4 == 0) ? a : {$urandom, $urandom};
      if (i % 5 == 0) b[63:32] = ~a[63:32];
      drive(a, b, 5'($urandom), 1'($urandom),
            (i % 3 == 0) ? FORCE_W'($urandom) : '0, "R7 R10 random vector");
    end
    wait (sb_q.size() == 0);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule